// File: doc/BRIEF.md
# Bus-to-Local Address Window Translator

This block sits behind the target side of a host bus interface and turns incoming bus addresses into addresses in the chip's local space. Four programmable windows each hold three registers. The bus base register appears in configuration space. The control register sets the space type, prefetch, byte swap, enable and window size. The mapping register holds the local base address. Each window covers a naturally aligned power-of-two range of bus addresses. A matching address is translated to the local base plus its offset inside the window.

For every presented address, the block returns a registered result one cycle later. The result holds a hit flag, the index of the selected window, the translated local address and that window's attributes. It also holds a last-beat flag. The flag marks that the next sequential beat would fall outside the window, so the target logic can end the burst with a disconnect that carries no data. Overlapping bus windows resolve to the lowest-numbered match. Windows that sit back to back still stop a burst at each edge.

Top module: `bus_window_xlate`

## Requirements
- R1: After reset every window is disabled, every register reads as zero, and no address hits. On a miss, the local address and all attribute outputs are zero.
- R2: An address hits window i when the window's enable bit (control bit 3) is set and the address matches the base register in every bit above the window size.
- R3: The local address equals the mapping register plus the address offset inside the window, formed by addition. The mapping register need not be aligned.
- R4: When several enabled windows match, the lowest-numbered one is reported.
- R5: Control bit 0 set marks an I/O window: the result flags I/O and the base readback shows bit 0 set.
- R6: Control bit 1 requests prefetch. The result's prefetch flag and base readback bit 3 follow it only for memory windows, and both stay 0 for I/O windows.
- R7: Control bit 2 is passed to the result as the byte-swap enable of the selected window.
- R8: The last-beat flag is set exactly when the address lies in the final 4-byte beat of its window, including when the next window starts at the adjacent address.
- R9: A result appears one cycle after a lookup request. With no request, the next result has its valid and hit flags low.
- R10: The size field (control bits 8:4) gives log2 of the window size in bytes. Values below 4 act as 4, giving a 16-byte window.
- R11: A base register reads back with all bits below the window size cleared, apart from the type bits of R5 and R6.
- R12: Register select 0 is base, 1 is control, 2 is mapping. Select 3 reads zero, and writes to it change nothing. Writes take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window index for register access |
| cfg_sel | input | 2 | Register select within the window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the addressed register |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | 32 | Bus address to translate |
| res_valid | output | 1 | Result valid, one cycle after a request |
| res_hit | output | 1 | Address fell inside an enabled window |
| res_win | output | 2 | Index of the selected window |
| res_local | output | 32 | Translated local address |
| res_io | output | 1 | Selected window is I/O space |
| res_prefetch | output | 1 | Selected window is prefetchable memory |
| res_swap | output | 1 | Byte swap enabled for the selected window |
| res_last | output | 1 | Address is in the final beat of its window |

## Verification
One window's mapping base is deliberately unaligned and the offset is chosen to carry into the base's bits. A design that combined base and offset with OR instead of addition would return the wrong local address. A large window laid over a smaller one checks the fixed priority, and disabling the large one exposes the smaller one underneath. Two back-to-back windows check that the final beat of the lower window raises the last-beat flag, and that one beat earlier does not. A design that let bursts run into the neighbouring window would miss that flag. Size values below the minimum, an I/O window with its prefetch bit set, and the unused register select each catch a design that trusts the raw field.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
    parameter int ADDR_W     = 32;
    parameter int NWIN       = 4;
    parameter int BEAT_BYTES = 4;
    parameter int SIZE_MIN   = 4;
    parameter int SIZE_W     = 5;

    localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int CTRL_W = SIZE_W + 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_MAP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              en;
        logic              swap;
        logic              pref;
        logic              io;
    } win_ctrl_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] win;
        addr_t            local_addr;
        logic             io;
        logic             pref;
        logic             swap;
        logic             last;
    } xlate_res_t;

    function automatic addr_t win_mask(input logic [SIZE_W-1:0] sz);
        int unsigned s;
        s = (int'(sz) < SIZE_MIN) ? SIZE_MIN : int'(sz);
        if (s >= ADDR_W)
            win_mask = '1;
        else
            win_mask = (addr_t'(1) << s) - addr_t'(1);
    endfunction
endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
    import bwx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_win,
    input  logic [1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    output addr_t                base_q [NWIN],
    output win_ctrl_t            ctrl_q [NWIN],
    output addr_t                map_q  [NWIN]
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(cfg_sel);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic hit_me;
        assign hit_me = cfg_we && (int'(cfg_win) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
                ctrl_q[g] <= '0;
                map_q[g]  <= '0;
            end else if (hit_me) begin
                case (sel)
                    SEL_BASE: base_q[g] <= cfg_wdata;
                    SEL_CTRL: ctrl_q[g] <= win_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    SEL_MAP:  map_q[g]  <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    addr_t     rd_base;
    win_ctrl_t rd_ctrl;
    addr_t     rd_map;
    addr_t     rd_mask;
    addr_t     rd_type;

    always_comb begin
        rd_base = '0;
        rd_ctrl = '0;
        rd_map  = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (int'(cfg_win) == i) begin
                rd_base = base_q[i];
                rd_ctrl = ctrl_q[i];
                rd_map  = map_q[i];
            end
        end
        rd_mask = win_mask(rd_ctrl.size);
        rd_type = '0;
        rd_type[0] = rd_ctrl.io;
        rd_type[3] = rd_ctrl.pref && !rd_ctrl.io;
        case (sel)
            SEL_BASE: cfg_rdata = (rd_base & ~rd_mask) | rd_type;
            SEL_CTRL: cfg_rdata = ADDR_W'(rd_ctrl);
            SEL_MAP:  cfg_rdata = rd_map;
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bwx_match.sv
module bwx_match
    import bwx_pkg::*;
(
    input  addr_t             addr,
    input  addr_t             base,
    input  logic              en,
    input  logic [SIZE_W-1:0] size,
    output logic              hit,
    output addr_t             offset,
    output logic              last
);
    localparam addr_t BEAT_LOW = addr_t'(BEAT_BYTES - 1);

    addr_t mask;
    assign mask   = win_mask(size);
    assign hit    = en && ((addr & ~mask) == (base & ~mask));
    assign offset = addr & mask;
    assign last   = hit && ((offset | BEAT_LOW) == mask);
endmodule

// File: rtl/bwx_pick.sv
module bwx_pick
    import bwx_pkg::*;
(
    input  logic [NWIN-1:0] hit,
    input  addr_t           offset [NWIN],
    input  logic [NWIN-1:0] last,
    input  addr_t           map    [NWIN],
    input  logic [NWIN-1:0] io,
    input  logic [NWIN-1:0] pref,
    input  logic [NWIN-1:0] swap,
    output xlate_res_t      res
);
    always_comb begin
        res = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                res.hit        = 1'b1;
                res.win        = IDX_W'(i);
                res.local_addr = map[i] + offset[i];
                res.io         = io[i];
                res.pref       = pref[i] && !io[i];
                res.swap       = swap[i];
                res.last       = last[i];
            end
        end
    end
endmodule

// File: rtl/bus_window_xlate.sv
module bus_window_xlate
    import bwx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_win,
    input  logic [1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    input  logic                 lookup_valid,
    input  logic [ADDR_W-1:0]    lookup_addr,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_win,
    output logic [ADDR_W-1:0]    res_local,
    output logic                 res_io,
    output logic                 res_prefetch,
    output logic                 res_swap,
    output logic                 res_last
);
    addr_t     base_q [NWIN];
    win_ctrl_t ctrl_q [NWIN];
    addr_t     map_q  [NWIN];

    bwx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .base_q    (base_q),
        .ctrl_q    (ctrl_q),
        .map_q     (map_q)
    );

    logic [NWIN-1:0] w_hit;
    logic [NWIN-1:0] w_last;
    logic [NWIN-1:0] w_io;
    logic [NWIN-1:0] w_pref;
    logic [NWIN-1:0] w_swap;
    addr_t           w_off [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign w_io[g]   = ctrl_q[g].io;
        assign w_pref[g] = ctrl_q[g].pref;
        assign w_swap[g] = ctrl_q[g].swap;

        bwx_match u_match (
            .addr   (lookup_addr),
            .base   (base_q[g]),
            .en     (ctrl_q[g].en),
            .size   (ctrl_q[g].size),
            .hit    (w_hit[g]),
            .offset (w_off[g]),
            .last   (w_last[g])
        );
    end

    xlate_res_t pick_res;

    bwx_pick u_pick (
        .hit    (w_hit),
        .offset (w_off),
        .last   (w_last),
        .map    (map_q),
        .io     (w_io),
        .pref   (w_pref),
        .swap   (w_swap),
        .res    (pick_res)
    );

    xlate_res_t res_q;
    logic       valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= lookup_valid;
            res_q   <= lookup_valid ? pick_res : '0;
        end
    end

    assign res_valid    = valid_q;
    assign res_hit      = res_q.hit;
    assign res_win      = res_q.win;
    assign res_local    = res_q.local_addr;
    assign res_io       = res_q.io;
    assign res_prefetch = res_q.pref;
    assign res_swap     = res_q.swap;
    assign res_last     = res_q.last;
endmodule

// File: rtl/bwx_checker.sv
module bwx_checker
    import bwx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lookup_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_win,
    input logic [ADDR_W-1:0] res_local,
    input logic              res_io,
    input logic              res_prefetch,
    input logic              res_swap,
    input logic              res_last
);
    a_r9_request_gives_result: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> res_valid);

    a_r9_idle_gives_no_result: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> (!res_valid && !res_hit));

    a_r1_miss_is_quiet: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_local == '0 && res_win == '0 && !res_io
                      && !res_prefetch && !res_swap && !res_last));

    a_r6_no_prefetch_on_io: assert property (@(posedge clk) disable iff (rst)
        res_prefetch |-> (res_hit && !res_io));

    a_r8_last_needs_hit: assert property (@(posedge clk) disable iff (rst)
        res_last |-> res_hit);
endmodule

bind bus_window_xlate bwx_checker u_bwx_checker (
    .clk          (clk),
    .rst          (rst),
    .lookup_valid (lookup_valid),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_win      (res_win),
    .res_local    (res_local),
    .res_io       (res_io),
    .res_prefetch (res_prefetch),
    .res_swap     (res_swap),
    .res_last     (res_last)
);

// File: tb/bus_window_xlate_bench.sv
module bus_window_xlate_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_addr = '0;
    logic        res_valid, res_hit, res_io, res_prefetch, res_swap, res_last;
    logic [1:0]  res_win;
    logic [31:0] res_local;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_window_xlate u_bus_window_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
        .res_local(res_local), .res_io(res_io), .res_prefetch(res_prefetch),
        .res_swap(res_swap), .res_last(res_last)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int win, input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 2'(win); cfg_sel = 2'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int win, input int sel, output logic [31:0] data);
        @(negedge clk);
        cfg_win = 2'(win); cfg_sel = 2'(sel);
        #1 data = cfg_rdata;
    endtask

    task automatic look(input logic [31:0] addr);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = addr;
        @(negedge clk);
        lookup_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input int win, input logic [31:0] loc,
                              input bit io, input bit pf, input bit sw, input bit last);
        check(req, "valid", 32'(res_valid), 32'd1);
        check(req, "hit", 32'(res_hit), 32'd1);
        check(req, "win", 32'(res_win), 32'(win));
        check(req, "local", res_local, loc);
        check(req, "io", 32'(res_io), 32'(io));
        check(req, "prefetch", 32'(res_prefetch), 32'(pf));
        check(req, "swap", 32'(res_swap), 32'(sw));
        check(req, "last", 32'(res_last), 32'(last));
    endtask

    task automatic expect_miss(input string req);
        check(req, "valid", 32'(res_valid), 32'd1);
        check(req, "hit", 32'(res_hit), 32'd0);
        check(req, "local", res_local, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 3; s++) begin
                rd(w, s, d);
                check("R1", "reset register", d, 32'd0);
            end
        look(32'h0000_0000);
        expect_miss("R1");
    endtask

    task automatic t_basic();
        logic [31:0] d;
        wr(1, 0, 32'h4000_0000);
        wr(1, 2, 32'h0010_0000);
        wr(1, 1, 32'h0000_00CE);
        look(32'h4000_0123);
        expect_hit("R2", 1, 32'h0010_0123, 0, 1, 1, 0);
        look(32'h4000_1000);
        expect_miss("R2");
        rd(1, 0, d);
        check("R6", "mem prefetch readback", d, 32'h4000_0008);
        rd(1, 1, d);
        check("R12", "ctrl readback", d, 32'h0000_00CE);
        check("R7", "swap on win1", 32'(d[2]), 32'd1);
    endtask

    task automatic t_add();
        wr(2, 0, 32'h5000_0000);
        wr(2, 2, 32'h0000_0FC0);
        wr(2, 1, 32'h0000_0088);
        look(32'h5000_0050);
        expect_hit("R3", 2, 32'h0000_1010, 0, 0, 0, 0);
    endtask

    task automatic t_io();
        logic [31:0] d;
        wr(3, 0, 32'h0000_10FF);
        wr(3, 2, 32'h2000_0000);
        wr(3, 1, 32'h0000_008F);
        rd(3, 0, d);
        check("R11", "io base readback", d, 32'h0000_1001);
        look(32'h0000_1004);
        expect_hit("R5", 3, 32'h2000_0004, 1, 0, 1, 0);
        look(32'h0000_10FC);
        expect_hit("R6", 3, 32'h2000_00FC, 1, 0, 1, 1);
    endtask

    task automatic t_overlap();
        wr(0, 0, 32'h4000_0000);
        wr(0, 2, 32'h7000_0000);
        wr(0, 1, 32'h0000_0108);
        look(32'h4000_0123);
        expect_hit("R4", 0, 32'h7000_0123, 0, 0, 0, 0);
        look(32'h4000_8000);
        expect_hit("R4", 0, 32'h7000_8000, 0, 0, 0, 0);
        wr(0, 1, 32'h0000_0000);
        look(32'h4000_0123);
        expect_hit("R4", 1, 32'h0010_0123, 0, 1, 1, 0);
    endtask

    task automatic t_edge();
        wr(2, 0, 32'h4000_1000);
        wr(2, 2, 32'h0800_0000);
        wr(2, 1, 32'h0000_00C8);
        look(32'h4000_0FFC);
        expect_hit("R8", 1, 32'h0010_0FFC, 0, 1, 1, 1);
        look(32'h4000_0FF8);
        expect_hit("R8", 1, 32'h0010_0FF8, 0, 1, 1, 0);
        look(32'h4000_0FFE);
        expect_hit("R8", 1, 32'h0010_0FFE, 0, 1, 1, 1);
        look(32'h4000_1000);
        expect_hit("R8", 2, 32'h0800_0000, 0, 0, 0, 0);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        wr(0, 0, 32'h6000_001F);
        wr(0, 2, 32'h0000_0000);
        wr(0, 1, 32'h0000_0028);
        rd(0, 0, d);
        check("R10", "clamped base readback", d, 32'h6000_0010);
        wr(0, 0, 32'h6000_0000);
        look(32'h6000_000C);
        expect_hit("R10", 0, 32'h0000_000C, 0, 0, 0, 1);
        look(32'h6000_0010);
        expect_miss("R10");
    endtask

    task automatic t_idle();
        @(negedge clk);
        lookup_valid = 1'b0; lookup_addr = 32'h4000_0123;
        @(negedge clk);
        check("R9", "idle valid", 32'(res_valid), 32'd0);
        check("R9", "idle hit", 32'(res_hit), 32'd0);
    endtask

    task automatic t_sel3();
        logic [31:0] d;
        wr(1, 3, 32'hFFFF_FFFF);
        rd(1, 3, d);
        check("R12", "select 3 reads zero", d, 32'd0);
        rd(1, 1, d);
        check("R12", "ctrl untouched", d, 32'h0000_00CE);
        look(32'h4000_0123);
        expect_hit("R12", 1, 32'h0010_0123, 0, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_add();
        t_io();
        t_overlap();
        t_edge();
        t_clamp();
        t_idle();
        t_sel3();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule